// File: doc/BRIEF.md
# Burst Local-Port Memory Emulator

This block stands in for the user side of an external memory controller. It keeps its storage in an on-chip RAM, so logic that drives a memory controller can be exercised without a physical DRAM. It follows the same request conventions as such a port. A write burst is fed one data word per request cycle. A read burst is launched by a single request and comes back as a stream of beats flagged by a valid strobe.

Addresses count beats, not bytes, so back-to-back bursts of length L sit at A, A+L, A+2L. The emulator also models the controller's power-up rule. The init-done flag comes up only if the controller reset input was held low for at least a configurable number of clock cycles. It adds a short backpressure window after each burst and a fixed read latency. It raises a flag for two kinds of protocol abuse: read and write requested in the same cycle, and a write burst cut short by a new one.

Top module: `burst_mem_emu`

## Requirements
- R1: `init_done_o` rises one cycle after `glob_rst_ni` is first sampled high, and only if `glob_rst_ni` was sampled low on at least RESET_HOLD consecutive clock edges just before that. It drops the cycle after `glob_rst_ni` is sampled low. A shorter low period leaves it low.
- R2: `ready_o` is low while `init_done_o` is low and while any beat of an accepted read burst is still to be returned.
- R3: A write beat is accepted on each edge where `wr_req_i` and `ready_o` are high and `rd_req_i` is low. The beat carrying `burst_begin_i` takes its address from `addr_i` and its length from `size_i`. Beat k of the burst lands at address+k.
- R4: A cycle with both `wr_req_i` and `rd_req_i` high writes nothing and starts no read. `proto_err_o` is high in the following cycle only.
- R5: Bit i of `be_i` enables bits 8i+7..8i of a written beat. Bytes whose enable bit is 0 keep their old contents.
- R6: A single accepted read request returns `size_i` beats in rising address order on consecutive cycles. The first beat shows `rdata_valid_o` READ_LAT cycles after the accepting edge.
- R7: After the edge that accepts the last beat of a write burst, or that accepts a read request, `ready_o` stays low for BP_CYCLES cycles. A request held while `ready_o` is low is not consumed.
- R8: A write beat with `burst_begin_i` that arrives while the previous write burst still has beats missing sets `short_err_o`. The flag holds until `rst_ni`.
- R9: Addresses wrap modulo DEPTH, which is a power of two, so only the low log2(DEPTH) address bits select a word.
- R10: A write beat without `burst_begin_i` while no write burst is open is dropped and alters no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the emulator |
| glob_rst_ni | input | 1 | Controller reset whose low hold gates init-done |
| init_done_o | output | 1 | Initialization complete |
| addr_i | input | ADDR_W | Beat address of a burst start |
| size_i | input | SIZE_W | Burst length in beats (1..2^SIZE_W-1) |
| burst_begin_i | input | 1 | Marks the first write beat of a burst |
| wr_req_i | input | 1 | Write beat request |
| be_i | input | DATA_W/8 | Byte enables of the write beat |
| wdata_i | input | DATA_W | Write beat data |
| rd_req_i | input | 1 | Read burst request |
| ready_o | output | 1 | Request accepted on this edge when high |
| rdata_o | output | DATA_W | Read beat data |
| rdata_valid_o | output | 1 | Read beat valid |
| proto_err_o | output | 1 | Simultaneous read/write request seen last cycle |
| short_err_o | output | 1 | Sticky truncated write burst flag |

## Verification
The properties assume that requests only change between clock edges. They also assume that `rst_ni` is low at time zero, so every flagged cycle follows a real reset. The stimulus changes all inputs on the falling edge. It holds each request steady until the design shows `ready_o` high. The only illegal request pattern it drives is the deliberate read/write clash, kept to a single cycle. All burst sizes stay within 1..127. No write burst is left open across a read, except in the truncated-burst case.

// File: rtl/bme_pkg.sv
package bme_pkg;
  typedef enum logic [1:0] {RD_IDLE, RD_WAIT, RD_STREAM} rd_phase_e;
endpackage

// File: rtl/bme_init_gate.sv
module bme_init_gate #(
  parameter int unsigned HOLD = 500000,
  localparam int unsigned CW = $clog2(HOLD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic glob_rst_ni,
  output logic init_done_o
);
  logic [CW-1:0] low_cnt_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q   <= '0;
      armed_q     <= 1'b0;
      init_done_o <= 1'b0;
    end else if (!glob_rst_ni) begin
      if (low_cnt_q != CW'(HOLD)) low_cnt_q <= low_cnt_q + CW'(1);
      // armed once this edge completes HOLD consecutive low samples
      armed_q     <= (low_cnt_q >= CW'(HOLD - 1));
      init_done_o <= 1'b0;
    end else begin
      low_cnt_q   <= '0;
      init_done_o <= armed_q;
    end
  end
endmodule

// File: rtl/bme_ram.sv
module bme_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] bit_mask;

  for (genvar b = 0; b < BE_W; b++) begin : g_mask
    assign bit_mask[b*8 +: 8] = {8{be_i[b]}};
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem[widx_i] <= (mem[widx_i] & ~bit_mask) | (wdata_i & bit_mask);
    if (re_i) rdata_o <= mem[ridx_i];
  end
endmodule

// File: rtl/bme_wr_ctrl.sv
module bme_wr_ctrl #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned SIZE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              begin_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              we_o,
  output logic [IDX_W-1:0]  widx_o,
  output logic              done_o,
  output logic              short_err_o
);
  logic [SIZE_W-1:0] left_q;
  logic [IDX_W-1:0]  ptr_q;
  logic              open_w;

  assign open_w = (left_q != '0);
  assign we_o   = fire_i && (begin_i || open_w);
  assign widx_o = begin_i ? idx_i : ptr_q;
  assign done_o = fire_i && (begin_i ? (size_i == SIZE_W'(1)) : (left_q == SIZE_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q      <= '0;
      ptr_q       <= '0;
      short_err_o <= 1'b0;
    end else if (fire_i && begin_i) begin
      if (open_w) short_err_o <= 1'b1;
      left_q <= size_i - SIZE_W'(1);
      ptr_q  <= idx_i + IDX_W'(1);
    end else if (fire_i && open_w) begin
      left_q <= left_q - SIZE_W'(1);
      ptr_q  <= ptr_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/bme_rd_ctrl.sv
module bme_rd_ctrl
  import bme_pkg::*;
#(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned SIZE_W = 7,
  parameter int unsigned LAT    = 4,
  localparam int unsigned WAIT_W = $clog2(LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              re_o,
  output logic [IDX_W-1:0]  ridx_o,
  output logic              valid_o,
  output logic              busy_o
);
  rd_phase_e         phase_q;
  logic [WAIT_W-1:0] wait_q;
  logic [SIZE_W-1:0] left_q;
  logic [IDX_W-1:0]  ptr_q;

  assign re_o   = (phase_q == RD_STREAM);
  assign ridx_o = ptr_q;
  assign busy_o = (phase_q != RD_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= RD_IDLE;
      wait_q  <= '0;
      left_q  <= '0;
      ptr_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= re_o;
      case (phase_q)
        RD_IDLE: if (fire_i) begin
          ptr_q   <= idx_i;
          left_q  <= size_i;
          wait_q  <= WAIT_W'(LAT - 1);
          phase_q <= (LAT == 1) ? RD_STREAM : RD_WAIT;
        end
        RD_WAIT: begin
          wait_q <= wait_q - WAIT_W'(1);
          if (wait_q == WAIT_W'(1)) phase_q <= RD_STREAM;
        end
        RD_STREAM: begin
          ptr_q  <= ptr_q + IDX_W'(1);
          left_q <= left_q - SIZE_W'(1);
          if (left_q == SIZE_W'(1)) phase_q <= RD_IDLE;
        end
        default: phase_q <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_mem_emu.sv
module burst_mem_emu #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned SIZE_W     = 7,
  parameter int unsigned RESET_HOLD = 500000,
  parameter int unsigned READ_LAT   = 4,
  parameter int unsigned BP_CYCLES  = 3,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned BP_W  = $clog2(BP_CYCLES + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              glob_rst_ni,
  output logic              init_done_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              burst_begin_i,
  input  logic              wr_req_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_req_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o,
  output logic              proto_err_o,
  output logic              short_err_o
);
  logic [BP_W-1:0]  bp_q;
  logic             rd_busy, wr_done, wr_fire, rd_fire;
  logic             ram_we, ram_re;
  logic [IDX_W-1:0] idx, widx, ridx;

  assign idx = addr_i[IDX_W-1:0];

  if (ADDR_W > IDX_W) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^addr_i[ADDR_W-1:IDX_W];
  end

  assign ready_o = init_done_o && (bp_q == '0) && !rd_busy;
  assign wr_fire = ready_o && wr_req_i && !rd_req_i;
  assign rd_fire = ready_o && rd_req_i && !wr_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_q        <= '0;
      proto_err_o <= 1'b0;
    end else begin
      proto_err_o <= wr_req_i && rd_req_i;
      if (wr_done || rd_fire) bp_q <= BP_W'(BP_CYCLES);
      else if (bp_q != '0)    bp_q <= bp_q - BP_W'(1);
    end
  end

  bme_init_gate #(.HOLD(RESET_HOLD)) i_init (
    .clk_i, .rst_ni, .glob_rst_ni, .init_done_o
  );

  bme_wr_ctrl #(.IDX_W(IDX_W), .SIZE_W(SIZE_W)) i_wr (
    .clk_i, .rst_ni,
    .fire_i(wr_fire), .begin_i(burst_begin_i), .idx_i(idx), .size_i,
    .we_o(ram_we), .widx_o(widx), .done_o(wr_done), .short_err_o
  );

  bme_rd_ctrl #(.IDX_W(IDX_W), .SIZE_W(SIZE_W), .LAT(READ_LAT)) i_rd (
    .clk_i, .rst_ni,
    .fire_i(rd_fire), .idx_i(idx), .size_i,
    .re_o(ram_re), .ridx_o(ridx), .valid_o(rdata_valid_o), .busy_o(rd_busy)
  );

  bme_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_ram (
    .clk_i, .we_i(ram_we), .widx_i(widx), .be_i, .wdata_i,
    .re_i(ram_re), .ridx_i(ridx), .rdata_o
  );
endmodule

// File: rtl/bme_checker.sv
module bme_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic glob_rst_ni,
  input logic wr_req_i,
  input logic rd_req_i,
  input logic ready_o,
  input logic init_done_o,
  input logic proto_err_o,
  input logic short_err_o
);
  assert_init_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glob_rst_ni |=> !init_done_o);

  assert_ready_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> !ready_o);

  assert_clash_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && rd_req_i) |=> proto_err_o);

  assert_read_backoff_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && rd_req_i && !wr_req_i) |=> !ready_o);

  assert_short_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_err_o |=> short_err_o);
endmodule

bind burst_mem_emu bme_checker i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .glob_rst_ni(glob_rst_ni),
  .wr_req_i(wr_req_i), .rd_req_i(rd_req_i), .ready_o(ready_o),
  .init_done_o(init_done_o), .proto_err_o(proto_err_o), .short_err_o(short_err_o)
);

// File: tb/test_burst_mem_emu.sv
module test_burst_mem_emu;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, DEP = 16, AW = 8, SW = 7, HOLD = 20, LAT = 3, BP = 2;

  logic clk = 0, rst_n = 0, g_rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [SW-1:0] size = '0;
  logic bb = 0, wr = 0, rd = 0;
  logic [3:0] be = '0;
  logic [DW-1:0] wdata = '0;
  logic ready_o, init_done_o, rdata_valid_o, proto_err_o, short_err_o;
  logic [DW-1:0] rdata_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_mem_emu #(.DATA_W(DW), .DEPTH(DEP), .ADDR_W(AW), .SIZE_W(SW),
    .RESET_HOLD(HOLD), .READ_LAT(LAT), .BP_CYCLES(BP)) i_burst_mem_emu (
    .clk_i(clk), .rst_ni(rst_n), .glob_rst_ni(g_rst_n), .init_done_o,
    .addr_i(addr), .size_i(size), .burst_begin_i(bb), .wr_req_i(wr),
    .be_i(be), .wdata_i(wdata), .rd_req_i(rd), .ready_o,
    .rdata_o, .rdata_valid_o, .proto_err_o, .short_err_o
  );

  int compared = 0, mismatched = 0, wd = 0;
  bit fin = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp,
                     input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [DW-1:0] m_mem [DEP];
  int lowrun, m_bp, m_wleft, m_wptr, cyc;
  bit armed, m_init, m_perr, m_serr, m_valid, pre_ready, wf, rf, done;
  logic [DW-1:0] m_rdata;
  int due_q[$];
  logic [DW-1:0] dat_q[$];
  logic [DW-1:0] got_q[$];

  function automatic void mwrite(input int a, input logic [DW-1:0] d, input logic [3:0] b);
    logic [DW-1:0] msk;
    for (int i = 0; i < 4; i++) msk[i*8 +: 8] = {8{b[i]}};
    m_mem[a % DEP] = (m_mem[a % DEP] & ~msk) | (d & msk);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      lowrun = 0; armed = 0; m_init = 0; m_bp = 0; m_wleft = 0; m_wptr = 0;
      m_perr = 0; m_serr = 0; m_valid = 0;
      due_q.delete(); dat_q.delete();
    end else begin
      pre_ready = m_init && m_bp == 0 && due_q.size() == 0;
      wf = wr && !rd && pre_ready;
      rf = rd && !wr && pre_ready;
      done = 0;
      m_perr = wr && rd;
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        m_valid = 1; m_rdata = dat_q[0];
        void'(due_q.pop_front()); void'(dat_q.pop_front());
      end else m_valid = 0;
      if (wf) begin
        if (bb) begin
          if (m_wleft > 0) m_serr = 1;
          mwrite(int'(addr), wdata, be);
          m_wleft = int'(size) - 1; m_wptr = int'(addr) + 1; done = (size == 1);
        end else if (m_wleft > 0) begin
          mwrite(m_wptr, wdata, be);
          m_wptr++; m_wleft--; done = (m_wleft == 0);
        end
      end
      if (rf) for (int k = 0; k < int'(size); k++) begin
        due_q.push_back(cyc + LAT + k);
        dat_q.push_back(m_mem[(int'(addr) + k) % DEP]);
      end
      if (done || rf) m_bp = BP; else if (m_bp > 0) m_bp--;
      if (!g_rst_n) begin lowrun++; armed = (lowrun >= HOLD); m_init = 0; end
      else begin m_init = armed; lowrun = 0; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk("R1", 32'(init_done_o), 32'(m_init), "model init_done");
      chk("R7", 32'(ready_o), 32'(m_init && m_bp == 0 && due_q.size() == 0), "model ready");
      chk("R6", 32'(rdata_valid_o), 32'(m_valid), "model rdata_valid");
      chk("R4", 32'(proto_err_o), 32'(m_perr), "model proto_err");
      chk("R8", 32'(short_err_o), 32'(m_serr), "model short_err");
      if (m_valid) chk("R6", rdata_o, m_rdata, "model rdata");
    end
    if (rdata_valid_o) got_q.push_back(rdata_o);
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !fin) begin
      fin = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic put_beats(input int a, input int decl, input int cnt, input logic [DW-1:0] base,
                           input logic [3:0] b, input bit first_bb);
    for (int k = 0; k < cnt; k++) begin
      wr = 1; bb = first_bb && (k == 0); addr = AW'(a); size = SW'(decl); be = b;
      wdata = base + DW'(k);
      while (!ready_o) @(negedge clk);
      @(negedge clk);
    end
    wr = 0; bb = 0;
  endtask

  task automatic rd_burst(input int a, input int n);
    got_q.delete();
    rd = 1; addr = AW'(a); size = SW'(n);
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    rd = 0;
    repeat (LAT + n + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2", 32'(ready_o), 0, "ready in reset");
    chk("R1", 32'(init_done_o), 0, "init in reset");
    chk("R6", 32'(rdata_valid_o), 0, "valid in reset");
    chk("R4", 32'(proto_err_o), 0, "proto_err in reset");
    chk("R8", 32'(short_err_o), 0, "short_err in reset");
    rst_n = 1;
    repeat (5) @(negedge clk);
    g_rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", 32'(init_done_o), 0, "init after short hold");
    chk("R2", 32'(ready_o), 0, "ready before init");
    g_rst_n = 0;
    repeat (25) @(negedge clk);
    g_rst_n = 1;
    @(negedge clk);
    chk("R1", 32'(init_done_o), 1, "init after full hold");
    chk("R2", 32'(ready_o), 1, "ready after init");

    // R3 basic burst, R7 backoff
    put_beats(0, 4, 4, 32'h1000_0000, 4'hF, 1);
    chk("R7", 32'(ready_o), 0, "ready after write burst");
    rd_burst(0, 4);
    chk("R6", 32'(got_q.size()), 4, "beat count");
    for (int k = 0; k < 4; k++) chk("R3", got_q[k], 32'h1000_0000 + k, "burst word");

    // R5 byte enables
    put_beats(5, 1, 1, 32'h1122_3344, 4'hF, 1);
    put_beats(5, 1, 1, 32'hAABB_CCDD, 4'b0101, 1);
    rd_burst(5, 1);
    chk("R5", got_q[0], 32'h11BB_33DD, "masked word");

    // R9 wrap
    put_beats(14, 4, 4, 32'h2000_0000, 4'hF, 1);
    rd_burst(0, 2);
    chk("R9", got_q[0], 32'h2000_0002, "wrapped beat 2");
    chk("R9", got_q[1], 32'h2000_0003, "wrapped beat 3");
    rd_burst(30, 1);
    chk("R9", got_q[0], 32'h2000_0000, "aliased address");

    // R2 / R6 second read held while first returns
    got_q.delete();
    rd = 1; addr = 8'd2; size = 7'd2;
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    chk("R2", 32'(ready_o), 0, "ready while read pending");
    addr = 8'd14; size = 7'd1;
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    rd = 0;
    repeat (LAT + 3) @(negedge clk);
    chk("R6", 32'(got_q.size()), 3, "beats of two reads");
    chk("R6", got_q[0], 32'h1000_0002, "first read beat 0");
    chk("R6", got_q[1], 32'h1000_0003, "first read beat 1");
    chk("R6", got_q[2], 32'h2000_0000, "second read");

    // R4 clash
    got_q.delete();
    wr = 1; rd = 1; bb = 1; addr = 8'd3; size = 7'd1; be = 4'hF; wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    wr = 0; rd = 0; bb = 0;
    chk("R4", 32'(proto_err_o), 1, "flag after clash");
    @(negedge clk);
    chk("R4", 32'(proto_err_o), 0, "flag one cycle");
    repeat (LAT + 2) @(negedge clk);
    chk("R4", 32'(got_q.size()), 0, "no read from clash");
    rd_burst(3, 1);
    chk("R4", got_q[0], 32'h1000_0003, "no write from clash");

    // R10 stray beat
    put_beats(11, 1, 1, 32'h6666_6666, 4'hF, 1);
    put_beats(9, 2, 2, 32'h3000_0000, 4'hF, 1);
    put_beats(0, 1, 1, 32'h5555_5555, 4'hF, 0);
    rd_burst(11, 1);
    chk("R10", got_q[0], 32'h6666_6666, "stray beat dropped");
    rd_burst(0, 1);
    chk("R10", got_q[0], 32'h2000_0002, "stray beat not at addr");

    // R8 truncated burst
    chk("R8", 32'(short_err_o), 0, "clean before truncation");
    put_beats(4, 4, 2, 32'h7000_0000, 4'hF, 1);
    put_beats(6, 1, 1, 32'h7100_0000, 4'hF, 1);
    chk("R8", 32'(short_err_o), 1, "set on truncation");
    repeat (5) @(negedge clk);
    chk("R8", 32'(short_err_o), 1, "sticky");
    rd_burst(4, 3);
    chk("R3", got_q[0], 32'h7000_0000, "partial beat 0");
    chk("R3", got_q[1], 32'h7000_0001, "partial beat 1");
    chk("R3", got_q[2], 32'h7100_0000, "new burst beat");

    // R1 drop and short re-hold
    g_rst_n = 0;
    @(negedge clk);
    chk("R1", 32'(init_done_o), 0, "init drops");
    chk("R2", 32'(ready_o), 0, "ready drops");
    @(negedge clk);
    g_rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", 32'(init_done_o), 0, "short re-hold");

    fin = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule